// File: doc/BRIEF.md
# Multi-Domain Lock-Gated Reset Controller

This block turns one shared active-low external reset into a separate active-low reset for each of several clock domains. Every output goes active at once when the external reset goes low, and no clock needs to be running for that. Each domain also has a lock indicator from its own clock source. A domain's reset is held active for as long as that indicator is low, so a domain never leaves reset on a clock that has not settled.

Once both the external reset and the domain's lock are high, release is carried through a three-stage flip-flop chain clocked by that domain. A constant one is shifted into the chain, which aligns the release to the domain's own clock edge. A saturating stretch counter then holds the reset for a set number of further cycles. That number is a separate parameter for each domain. If a lock falls later, only that domain re-enters reset, at once and with no clock edge needed, and the whole sequence runs again when lock returns.

Top module: `lockgate_rst_ctrl`

## Requirements
- R1: While `ext_rst_n_i` is low, every bit of `dom_rst_n_o` is low (0 = in reset). A fall of `ext_rst_n_i` drives all outputs low at once, with no clock edge needed.
- R2: An output can only go high on a rising edge of its own domain clock. With the clocks stopped, no output is released even when the external reset and all locks are high.
- R3: While `lock_i[d]` is low, `dom_rst_n_o[d]` stays low.
- R4: Once `ext_rst_n_i` and `lock_i[d]` are both high, `dom_rst_n_o[d]` goes high on exactly the (S_d + 3)-th rising edge of `clk_i[d]`. The 3 is the chain depth. S_d is the 16-bit field `STRETCH_CYC[16*d +: 16]`, so domain 0 uses the low field.
- R5: After release, `dom_rst_n_o[d]` stays high for as long as `ext_rst_n_i` and `lock_i[d]` stay high. The stretch counter saturates and does not wrap.
- R6: A fall of `lock_i[d]` after release drives `dom_rst_n_o[d]` low at once, with no clock edge. When lock returns, the full S_d + 3 edge sequence repeats.
- R7: Loss and return of one domain's lock leave every other domain's output unchanged.
- R8: When `ext_rst_n_i` rises while all locks are already high, each domain releases on its own (S_d + 3)-th clock edge, independently of the other domains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | N_DOM | One clock per domain |
| ext_rst_n_i | input | 1 | Shared external reset, active low, asynchronous |
| lock_i | input | N_DOM | Clock-source lock indicator per domain, asynchronous |
| dom_rst_n_o | output | N_DOM | Active-low reset per domain |

## Verification
The bench drives reset with every clock stopped. A design that asserted its reset through a synchronous path would leave the outputs high or undefined there, and one that leaked release without a clock edge would go high there. It counts domain edges from lock and from external-reset release in domains with stretch values of 16, 5 and 8. This exposes an off-by-one in the counter or the chain, and also a counter shared across domains. It drops one lock mid-run and looks at all outputs within a fraction of a nanosecond. A design that re-asserted reset only on a clock edge, disturbed the other domains, or failed to restart the stretch on relock would be caught there.

// File: rtl/mdrg_pkg.sv
package mdrg_pkg;

   // Bits needed to hold values 0..n (at least one bit).
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

   localparam int unsigned MDRG_MAX_STAGES = 8;

endpackage

// File: rtl/mdrg_sync.sv
// Release synchronizer: asynchronous clear, constant one shifted in.
module mdrg_sync #(
   parameter int unsigned STAGES = 3
) (
   input  logic clk_i,
   input  logic arst_n_i,
   output logic rel_o
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
   end

   assign rel_o = chain_q[STAGES-1];

endmodule

// File: rtl/mdrg_stretch.sv
// Saturating hold-off counter started by the synchronized release.
module mdrg_stretch
   import mdrg_pkg::*;
#(
   parameter int unsigned STRETCH = 16
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic start_i,
   output logic done_o
);

   localparam int unsigned CNT_W = cnt_width(STRETCH);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STRETCH - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             done_q;

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (start_i && !done_q) begin
         if (cnt_q == LAST) begin
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign done_o = done_q;

endmodule

// File: rtl/mdrg_domain.sv
// One domain: lock gating, release synchronizer, optional stretch.
module mdrg_domain #(
   parameter int unsigned SYNC_STAGES = 3,
   parameter int unsigned STRETCH     = 16
) (
   input  logic clk_i,
   input  logic ext_rst_n_i,
   input  logic lock_i,
   output logic rst_n_o
);

   logic gate_n;
   logic rel;

   // Lock is asynchronous: it joins the external reset before the chain.
   assign gate_n = ext_rst_n_i & lock_i;

   mdrg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i    (clk_i),
      .arst_n_i (gate_n),
      .rel_o    (rel)
   );

   if (STRETCH == 0) begin : g_no_stretch
      assign rst_n_o = rel;
   end else begin : g_stretch
      mdrg_stretch #(.STRETCH(STRETCH)) u_stretch (
         .clk_i    (clk_i),
         .arst_n_i (gate_n),
         .start_i  (rel),
         .done_o   (rst_n_o)
      );
   end

endmodule

// File: rtl/lockgate_rst_ctrl.sv
module lockgate_rst_ctrl
   import mdrg_pkg::*;
#(
   parameter int unsigned               N_DOM       = 3,
   parameter int unsigned               SYNC_STAGES = 3,
   parameter int unsigned               STRETCH_W   = 16,
   parameter logic [N_DOM*STRETCH_W-1:0] STRETCH_CYC = {N_DOM{STRETCH_W'(16)}}
) (
   input  logic [N_DOM-1:0] clk_i,
   input  logic             ext_rst_n_i,
   input  logic [N_DOM-1:0] lock_i,
   output logic [N_DOM-1:0] dom_rst_n_o
);

   if (N_DOM < 1) begin : g_bad_ndom
      $error("lockgate_rst_ctrl: N_DOM must be at least 1");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > MDRG_MAX_STAGES) begin : g_bad_sync
      $error("lockgate_rst_ctrl: SYNC_STAGES out of range");
   end
   if (STRETCH_W < 1 || STRETCH_W > 31) begin : g_bad_sw
      $error("lockgate_rst_ctrl: STRETCH_W out of range");
   end

   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      localparam int unsigned S_D = 32'(STRETCH_CYC[d*STRETCH_W +: STRETCH_W]);

      mdrg_domain #(
         .SYNC_STAGES (SYNC_STAGES),
         .STRETCH     (S_D)
      ) u_dom (
         .clk_i       (clk_i[d]),
         .ext_rst_n_i (ext_rst_n_i),
         .lock_i      (lock_i[d]),
         .rst_n_o     (dom_rst_n_o[d])
      );
   end

endmodule

// File: rtl/mdrg_chk.sv
module mdrg_chk #(
   parameter int unsigned               N_DOM       = 3,
   parameter int unsigned               SYNC_STAGES = 3,
   parameter int unsigned               STRETCH_W   = 16,
   parameter logic [N_DOM*STRETCH_W-1:0] STRETCH_CYC = {N_DOM{STRETCH_W'(16)}}
) (
   input logic [N_DOM-1:0] clk_i,
   input logic             ext_rst_n_i,
   input logic [N_DOM-1:0] lock_i,
   input logic [N_DOM-1:0] dom_rst_n_o
);

   for (genvar d = 0; d < N_DOM; d++) begin : g_chk
      localparam int unsigned S_D  = 32'(STRETCH_CYC[d*STRETCH_W +: STRETCH_W]);
      localparam logic [31:0] WANT = 32'(S_D + SYNC_STAGES);

      // Edges seen with external reset and lock both high, saturating.
      logic [31:0] run_q;
      always_ff @(posedge clk_i[d]) begin
         if (!(ext_rst_n_i && lock_i[d])) begin
            run_q <= '0;
         end else if (run_q != 32'hFFFF_FFFF) begin
            run_q <= run_q + 32'd1;
         end
      end

      p_ext_holds_r1: assert property (@(posedge clk_i[d])
         !ext_rst_n_i |-> !dom_rst_n_o[d]);

      p_unlocked_held_r3: assert property (@(posedge clk_i[d]) disable iff (!ext_rst_n_i)
         !lock_i[d] |-> !dom_rst_n_o[d]);

      p_release_count_r4: assert property (@(posedge clk_i[d]) disable iff (!ext_rst_n_i)
         $rose(dom_rst_n_o[d]) |-> (run_q == WANT));

      p_no_early_r2: assert property (@(posedge clk_i[d]) disable iff (!ext_rst_n_i)
         dom_rst_n_o[d] |-> (run_q >= WANT));

      p_stays_released_r5: assert property (@(posedge clk_i[d]) disable iff (!ext_rst_n_i)
         (dom_rst_n_o[d] && lock_i[d]) |=> (dom_rst_n_o[d] || !lock_i[d]));
   end

endmodule

bind lockgate_rst_ctrl mdrg_chk #(
   .N_DOM       (N_DOM),
   .SYNC_STAGES (SYNC_STAGES),
   .STRETCH_W   (STRETCH_W),
   .STRETCH_CYC (STRETCH_CYC)
) u_chk (.*);

// File: tb/lockgate_rst_ctrl_tb.sv
`timescale 1ns/1ps
module lockgate_rst_ctrl_tb;

   localparam int N  = 3;
   localparam int SW = 16;
   localparam logic [N*SW-1:0] SCYC = {16'd8, 16'd5, 16'd16};

   logic       c0, c1, c2, run;
   logic [2:0] clk;
   logic       ext;
   logic [2:0] lock;
   logic [2:0] rst_n;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;
   int m0, m1, m2;

   assign clk = {c2, c1, c0};

   lockgate_rst_ctrl #(
      .N_DOM(N), .SYNC_STAGES(3), .STRETCH_W(SW), .STRETCH_CYC(SCYC)
   ) u_dut (
      .clk_i(clk), .ext_rst_n_i(ext), .lock_i(lock), .dom_rst_n_o(rst_n)
   );

   // Domain 0 at 250 MHz; the others are offset so no edges coincide.
   initial begin c0 = 0; forever #2 c0 = run ? ~c0 : 1'b0; end
   initial begin c1 = 0; #0.7; forever #3 c1 = run ? ~c1 : 1'b0; end
   initial begin c2 = 0; #0.3; forever #5 c2 = run ? ~c2 : 1'b0; end

   function automatic int sexp(input int d);
      return int'(SCYC[d*SW +: SW]) + 3;
   endfunction

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_edge(input int d);
      case (d)
         0: @(posedge c0);
         1: @(posedge c1);
         default: @(posedge c2);
      endcase
   endtask

   task automatic measure(input int d, output int n);
      n = 0;
      while (n < 200) begin
         wait_edge(d);
         #0.2;
         n++;
         if (rst_n[d]) break;
      end
   endtask

   task automatic t_no_clock();
      run = 0; ext = 0; lock = 3'b000;
      #20;
      check_eq("R1", "reset state, clocks stopped", int'(rst_n), 0);
      lock = 3'b111; ext = 1;
      #50;
      check_eq("R2", "no release without clock edges", int'(rst_n), 0);
      lock = 3'b000;
      #5;
   endtask

   task automatic t_lock_gate();
      run = 1;
      #200;
      check_eq("R3", "all held while unlocked", int'(rst_n), 0);
   endtask

   task automatic t_release_each();
      int n;
      for (int d = 0; d < N; d++) begin
         @(posedge c0); #1;
         lock[d] = 1'b1;
         measure(d, n);
         check_eq("R4", $sformatf("release edges dom%0d", d), n, sexp(d));
         for (int e = d + 1; e < N; e++)
            check_eq("R3", $sformatf("dom%0d still held", e), int'(rst_n[e]), 0);
      end
      #300;
      check_eq("R5", "all stay released", int'(rst_n), 7);
   endtask

   task automatic t_lock_loss();
      int n;
      @(posedge c0); #1;
      lock[1] = 1'b0;
      #0.1;
      check_eq("R6", "dom1 asserts without edge", int'(rst_n[1]), 0);
      check_eq("R7", "dom0 unaffected", int'(rst_n[0]), 1);
      check_eq("R7", "dom2 unaffected", int'(rst_n[2]), 1);
      #40;
      check_eq("R3", "dom1 held while unlocked", int'(rst_n[1]), 0);
      @(posedge c0); #1;
      lock[1] = 1'b1;
      measure(1, n);
      check_eq("R6", "dom1 relock edges", n, sexp(1));
      check_eq("R7", "others kept after relock", int'({rst_n[2], rst_n[0]}), 3);
   endtask

   task automatic t_ext_pulse();
      @(posedge c0); #1;
      ext = 1'b0;
      #0.1;
      check_eq("R1", "ext assert without edge", int'(rst_n), 0);
      #30;
      @(posedge c0); #1;
      ext = 1'b1;
      fork
         measure(0, m0);
         measure(1, m1);
         measure(2, m2);
      join
      check_eq("R8", "dom0 edges after ext release", m0, sexp(0));
      check_eq("R8", "dom1 edges after ext release", m1, sexp(1));
      check_eq("R8", "dom2 edges after ext release", m2, sexp(2));
   endtask

   task automatic t_stop_then_reset();
      run = 0;
      #20;
      ext = 1'b0;
      #1;
      check_eq("R1", "assert with clocks stopped", int'(rst_n), 0);
   endtask

   initial begin
      t_no_clock();
      t_lock_gate();
      t_release_each();
      t_lock_loss();
      t_ext_pulse();
      t_stop_then_reset();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule